// File: doc/BRIEF.md
# PC Card Configuration Register Set

This block holds the four byte-wide registers through which a host configures a removable storage card over its attribute space. The host reads and writes them with single-cycle strobes. They select the card's addressing mode, request power-down, hold the card in reset by software, identify the card's copy number when several cards are fitted, and report card status. The registers sit at the even addresses 200h, 202h, 204h and 206h. When the card is strapped for disk-drive emulation mode, they are invisible.

The block also drives three outputs towards the host. The first is an active-low status-change signal, gated by a latched ready/busy-changed flag. The second is an active-low interrupt that is either a fixed-length pulse per new request or a level that follows the request. The third is the ready state reported to the host, which the block holds busy while a power-state change is in progress.

Two small state machines carry the sequencing. The power machine has states ACTIVE, ENTER, ASLEEP and LEAVE:
- ACTIVE→ENTER when power-down is requested.
- ENTER→ASLEEP when the core acknowledges.
- ENTER→LEAVE if the request is withdrawn.
- ASLEEP→LEAVE when the request is cleared.
- LEAVE→ACTIVE when the acknowledge drops.
- LEAVE→ENTER if the request returns.

The interrupt machine has states IDLE, PULSE and LEVEL:
- IDLE→PULSE on a request rising edge in pulse mode.
- IDLE→LEVEL on a high request in level mode.
- PULSE→PULSE (restart) on a new rising edge.
- PULSE→IDLE after the pulse length.
- PULSE→LEVEL or IDLE when level mode is selected.
- LEVEL→IDLE when the request drops or pulse mode is selected.

Top module: `card_cfg_regs`

## Requirements
- R1: After hard reset every register reads 00h, except the pin register, which reads 05h while ready is reported. At the same time card_rst=0, mode_idx=0, stschg_n=1 and irq_n=1.
- R2: The option register sits at 200h. Bit 7 is the soft reset. Bit 6 selects level interrupts when 1 and pulse interrupts when 0. Bits 5:0 are the mode index, which is driven on mode_idx and read back.
- R3: Writing 1 to option bit 7 sets card_rst, and the bit stays 1 until the host writes it 0. The same write clears every other register field to its reset value. While the bit is 1, fields stay cleared and writes to other registers are ignored.
- R4: The changed flag is pin register bit 1. It sets when the reported ready state changes while the change enable (pin bit 2, reset 1) is 1. The host may write it. When a ready change and a host write fall in the same cycle, the set wins.
- R5: stschg_n is 0 exactly when the signal-change enable (status bit 2) is 1, the changed flag is 1 and the mode index is non-zero. Otherwise it is 1.
- R6: The status register sits at 202h. Bit 0 is read-only and reads irq_req AND dev_ien. Bit 1 is the power-down request, bit 2 the signal-change enable and bit 3 the 8-bit host flag. Bit 4 mirrors the changed flag, and the other bits read 0.
- R7: A change of the power-down bit makes the reported ready state busy from the following cycle. It stays busy until pwr_ack equals the request. pwr_down is 1 in ENTER and ASLEEP.
- R8: The pin register sits at 204h. Bit 0 reads the reported ready state, bit 1 is the changed flag and bit 2 the change enable. The other bits read 0.
- R9: The socket register sits at 206h. Bit 4 is a writable drive number, and the other bits read 0 and ignore writes.
- R10: In pulse mode each rising edge of the masked request drives irq_n low for exactly 4 cycles, starting the cycle after the edge. A request held high gives no further pulse, and a masked request gives none.
- R11: In level mode irq_n is the inverse of the masked request, delayed by one clock.
- R12: Accesses to odd addresses and unmapped addresses read 00h and change nothing. When ide_mode=1, every access reads 00h and every write is ignored.
- R13: attr_rdata is 00h whenever attr_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| ide_mode | input | 1 | Disk-emulation strap; hides the registers |
| attr_rd | input | 1 | Attribute read strobe |
| attr_wr | input | 1 | Attribute write strobe |
| attr_addr | input | 12 | Attribute byte address |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Read data |
| rdy_in | input | 1 | Core ready (1) / busy (0) |
| pwr_ack | input | 1 | Core reports the low-power state as reached |
| dev_ien | input | 1 | Device-control interrupt enable |
| irq_req | input | 1 | Internal interrupt request |
| card_rst | output | 1 | Card held in soft reset |
| mode_idx | output | 6 | Mode index |
| pwr_down | output | 1 | Low-power request towards the core |
| stschg_n | output | 1 | Status-change signal, active low |
| irq_n | output | 1 | Interrupt to host, active low |

## Verification
A ready/busy transition can arrive in the same clock as a host write to the pin register that clears the changed flag. The bench provokes this by dropping rdy_in at the same falling edge where it launches a write of 04h to 204h. It then reads the pin register back, and the readback must show the flag set and the enable kept, 06h. The same flag also feeds stschg_n, so the status-change path is judged against the flag and enable values the bench's model expects.

// File: rtl/card_cfg_pkg.sv
`timescale 1ns/1ps
package card_cfg_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = DATA_W - 2;

    // register offsets from the base address
    localparam int OFS_OPT  = 0;
    localparam int OFS_STAT = 2;
    localparam int OFS_PIN  = 4;
    localparam int OFS_SOCK = 6;

    // option register fields
    localparam int OPT_SRST = 7;
    localparam int OPT_LVL  = 6;

    // status register fields
    localparam int ST_INTR = 0;
    localparam int ST_PD   = 1;
    localparam int ST_SIG  = 2;
    localparam int ST_B8   = 3;
    localparam int ST_CHG  = 4;

    // pin register fields
    localparam int PIN_RDY = 0;
    localparam int PIN_CHG = 1;
    localparam int PIN_EN  = 2;

    // socket register field
    localparam int SOCK_DRV = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OPT,
        SEL_STAT,
        SEL_PIN,
        SEL_SOCK
    } reg_sel_e;

    typedef enum logic [1:0] {
        PW_ACTIVE,
        PW_ENTER,
        PW_ASLEEP,
        PW_LEAVE
    } pwr_state_e;

    typedef enum logic [1:0] {
        IQ_IDLE,
        IQ_PULSE,
        IQ_LEVEL
    } irq_state_e;

endpackage

// File: rtl/card_cfg_regfile.sv
`timescale 1ns/1ps
module card_cfg_regfile
    import card_cfg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ide_mode,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rdy_rep,
    input  logic              dev_ien,
    input  logic              irq_req,
    output logic              irq_act,
    output logic              srst,
    output logic              lvl_mode,
    output logic [IDX_W-1:0]  idx,
    output logic              pd_req,
    output logic              stschg_n
);

    localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(BASE_ADDR + OFS_OPT);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_ADDR + OFS_STAT);
    localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(BASE_ADDR + OFS_PIN);
    localparam logic [ADDR_W-1:0] A_SOCK = ADDR_W'(BASE_ADDR + OFS_SOCK);

    reg_sel_e         sel;
    logic             srst_q, lvl_q, pd_q, sig_q, b8_q, chg_q, chg_en_q, drv_q;
    logic [IDX_W-1:0] idx_q;
    logic             rdy_prev_q, prev_ok_q;
    logic             wr_opt, wr_stat, wr_pin, wr_sock;
    logic             clear_all, rdy_edge;
    logic [DATA_W-1:0] rd_word;

    // address decode; hidden entirely in disk-emulation mode
    always_comb begin
        sel = SEL_NONE;
        if (!ide_mode) begin
            if      (addr == A_OPT)  sel = SEL_OPT;
            else if (addr == A_STAT) sel = SEL_STAT;
            else if (addr == A_PIN)  sel = SEL_PIN;
            else if (addr == A_SOCK) sel = SEL_SOCK;
        end
    end

    assign wr_opt  = wr && (sel == SEL_OPT);
    assign wr_stat = wr && (sel == SEL_STAT);
    assign wr_pin  = wr && (sel == SEL_PIN);
    assign wr_sock = wr && (sel == SEL_SOCK);

    assign clear_all = srst_q || (wr_opt && wdata[OPT_SRST]);
    assign rdy_edge  = prev_ok_q && (rdy_rep != rdy_prev_q);
    assign irq_act   = irq_req && dev_ien;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_q     <= 1'b0;
            lvl_q      <= 1'b0;
            idx_q      <= '0;
            pd_q       <= 1'b0;
            sig_q      <= 1'b0;
            b8_q       <= 1'b0;
            chg_q      <= 1'b0;
            chg_en_q   <= 1'b1;
            drv_q      <= 1'b0;
            rdy_prev_q <= 1'b0;
            prev_ok_q  <= 1'b0;
        end else begin
            rdy_prev_q <= rdy_rep;
            prev_ok_q  <= 1'b1;
            if (clear_all) begin
                srst_q   <= wr_opt ? wdata[OPT_SRST] : 1'b1;
                lvl_q    <= 1'b0;
                idx_q    <= '0;
                pd_q     <= 1'b0;
                sig_q    <= 1'b0;
                b8_q     <= 1'b0;
                chg_q    <= 1'b0;
                chg_en_q <= 1'b1;
                drv_q    <= 1'b0;
            end else begin
                if (wr_opt) begin
                    lvl_q <= wdata[OPT_LVL];
                    idx_q <= wdata[IDX_W-1:0];
                end
                if (wr_stat) begin
                    pd_q  <= wdata[ST_PD];
                    sig_q <= wdata[ST_SIG];
                    b8_q  <= wdata[ST_B8];
                end
                if (rdy_edge && chg_en_q) begin
                    chg_q <= 1'b1;
                end else if (wr_pin) begin
                    chg_q <= wdata[PIN_CHG];
                end
                if (wr_pin) begin
                    chg_en_q <= wdata[PIN_EN];
                end
                if (wr_sock) begin
                    drv_q <= wdata[SOCK_DRV];
                end
            end
        end
    end

    // read multiplexer
    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_OPT: begin
                rd_word[OPT_SRST]    = srst_q;
                rd_word[OPT_LVL]     = lvl_q;
                rd_word[IDX_W-1:0]   = idx_q;
            end
            SEL_STAT: begin
                rd_word[ST_INTR] = irq_act;
                rd_word[ST_PD]   = pd_q;
                rd_word[ST_SIG]  = sig_q;
                rd_word[ST_B8]   = b8_q;
                rd_word[ST_CHG]  = chg_q;
            end
            SEL_PIN: begin
                rd_word[PIN_RDY] = rdy_rep;
                rd_word[PIN_CHG] = chg_q;
                rd_word[PIN_EN]  = chg_en_q;
            end
            SEL_SOCK: begin
                rd_word[SOCK_DRV] = drv_q;
            end
            SEL_NONE: rd_word = '0;
            default:  rd_word = '0;
        endcase
        rdata = rd ? rd_word : '0;
    end

    assign srst     = srst_q;
    assign lvl_mode = lvl_q;
    assign idx      = idx_q;
    assign pd_req   = pd_q;
    assign stschg_n = !(sig_q && chg_q && (idx_q != '0));

    // soft reset keeps the mode index and interrupt mode cleared (R3)
    p_srst_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |-> (idx_q == '0) && !lvl_q && !chg_q);

    // a ready change with the enable set always leaves the flag set (R4)
    p_chg_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_edge && chg_en_q && !clear_all) |=> chg_q);

    // disk-emulation mode freezes the host-written fields (R12)
    p_ide_nowrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_mode && !srst_q) |=> $stable(idx_q) && $stable(lvl_q) && $stable(drv_q) && $stable(srst_q));

endmodule

// File: rtl/card_cfg_pwr.sv
`timescale 1ns/1ps
module card_cfg_pwr
    import card_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic card_rst,
    input  logic pd_req,
    input  logic pwr_ack,
    input  logic rdy_in,
    output logic rdy_rep,
    output logic pwr_down
);

    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_ACTIVE: if (pd_req)  state_d = PW_ENTER;
            PW_ENTER: begin
                if (!pd_req)      state_d = PW_LEAVE;
                else if (pwr_ack) state_d = PW_ASLEEP;
            end
            PW_ASLEEP: if (!pd_req) state_d = PW_LEAVE;
            PW_LEAVE: begin
                if (pd_req)        state_d = PW_ENTER;
                else if (!pwr_ack) state_d = PW_ACTIVE;
            end
            default: state_d = PW_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= PW_ACTIVE;
        else if (card_rst) state_q <= PW_ACTIVE;
        else               state_q <= state_d;
    end

    always_comb begin
        rdy_rep  = 1'b0;
        pwr_down = 1'b0;
        unique case (state_q)
            PW_ACTIVE: rdy_rep = rdy_in;
            PW_ENTER:  pwr_down = 1'b1;
            PW_ASLEEP: begin
                rdy_rep  = rdy_in;
                pwr_down = 1'b1;
            end
            PW_LEAVE:  rdy_rep = 1'b0;
            default:   rdy_rep = 1'b0;
        endcase
    end

    // a change of the power request reports busy on the next cycle (R7)
    p_busy_switch_r7: assert property (@(posedge clk) disable iff (!rst_n || card_rst)
        !$stable(pd_req) |=> !rdy_rep);

endmodule

// File: rtl/card_cfg_irq.sv
`timescale 1ns/1ps
module card_cfg_irq
    import card_cfg_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_rst,
    input  logic lvl_mode,
    input  logic req,
    output logic irq_n
);

    localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_LEN - 1);

    irq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             req_q, rise;

    assign rise = req && !req_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            IQ_IDLE: begin
                if (lvl_mode && req) begin
                    state_d = IQ_LEVEL;
                end else if (!lvl_mode && rise) begin
                    state_d = IQ_PULSE;
                    cnt_d   = '0;
                end
            end
            IQ_PULSE: begin
                if (lvl_mode) begin
                    state_d = req ? IQ_LEVEL : IQ_IDLE;
                end else if (rise) begin
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = IQ_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            IQ_LEVEL: begin
                if (!lvl_mode || !req) state_d = IQ_IDLE;
            end
            default: state_d = IQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IQ_IDLE;
            cnt_q   <= '0;
            req_q   <= 1'b0;
        end else if (card_rst) begin
            state_q <= IQ_IDLE;
            cnt_q   <= '0;
            req_q   <= req;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            req_q   <= req;
        end
    end

    always_comb begin
        unique case (state_q)
            IQ_PULSE: irq_n = 1'b0;
            IQ_LEVEL: irq_n = 1'b0;
            default:  irq_n = 1'b1;
        endcase
    end

    // a pulse, once started in pulse mode, lasts past its first cycle (R10)
    p_pulse_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || card_rst)
        (!lvl_mode && $fell(irq_n)) |=> !irq_n);

    // level mode: output asserted one cycle after a high request (R11)
    p_level_on_r11: assert property (@(posedge clk) disable iff (!rst_n || card_rst)
        (lvl_mode && req) |=> !irq_n);

    // level mode: output released one cycle after the request drops (R11)
    p_level_off_r11: assert property (@(posedge clk) disable iff (!rst_n || card_rst)
        (lvl_mode && !req) |=> irq_n);

endmodule

// File: rtl/card_cfg_regs.sv
`timescale 1ns/1ps
module card_cfg_regs
    import card_cfg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 'h200,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ide_mode,
    input  logic              attr_rd,
    input  logic              attr_wr,
    input  logic [ADDR_W-1:0] attr_addr,
    input  logic [7:0]        attr_wdata,
    output logic [7:0]        attr_rdata,
    input  logic              rdy_in,
    input  logic              pwr_ack,
    input  logic              dev_ien,
    input  logic              irq_req,
    output logic              card_rst,
    output logic [5:0]        mode_idx,
    output logic              pwr_down,
    output logic              stschg_n,
    output logic              irq_n
);

    logic rdy_rep, irq_act, lvl_mode, pd_req;

    card_cfg_regfile #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ide_mode (ide_mode),
        .rd       (attr_rd),
        .wr       (attr_wr),
        .addr     (attr_addr),
        .wdata    (attr_wdata),
        .rdata    (attr_rdata),
        .rdy_rep  (rdy_rep),
        .dev_ien  (dev_ien),
        .irq_req  (irq_req),
        .irq_act  (irq_act),
        .srst     (card_rst),
        .lvl_mode (lvl_mode),
        .idx      (mode_idx),
        .pd_req   (pd_req),
        .stschg_n (stschg_n)
    );

    card_cfg_pwr u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .card_rst (card_rst),
        .pd_req   (pd_req),
        .pwr_ack  (pwr_ack),
        .rdy_in   (rdy_in),
        .rdy_rep  (rdy_rep),
        .pwr_down (pwr_down)
    );

    card_cfg_irq #(
        .PULSE_LEN (PULSE_LEN)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .card_rst (card_rst),
        .lvl_mode (lvl_mode),
        .req      (irq_act),
        .irq_n    (irq_n)
    );

endmodule

// File: tb/card_cfg_regs_test.sv
`timescale 1ns/1ps
module card_cfg_regs_test;

    localparam logic [11:0] A_OPT  = 12'h200;
    localparam logic [11:0] A_STAT = 12'h202;
    localparam logic [11:0] A_PIN  = 12'h204;
    localparam logic [11:0] A_SOCK = 12'h206;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ide_mode = 1'b0;
    logic        attr_rd = 1'b0;
    logic        attr_wr = 1'b0;
    logic [11:0] attr_addr = '0;
    logic [7:0]  attr_wdata = '0;
    logic [7:0]  attr_rdata;
    logic        rdy_in = 1'b1;
    logic        pwr_ack = 1'b0;
    logic        dev_ien = 1'b0;
    logic        irq_req = 1'b0;
    logic        card_rst;
    logic [5:0]  mode_idx;
    logic        pwr_down;
    logic        stschg_n;
    logic        irq_n;

    int n_chk = 0;
    int n_fail = 0;

    // model of the host-visible fields used in the random phase
    logic [7:0] m_opt, m_stat, m_pin, m_sock;

    always #4 clk = ~clk;

    card_cfg_regs uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ide_mode   (ide_mode),
        .attr_rd    (attr_rd),
        .attr_wr    (attr_wr),
        .attr_addr  (attr_addr),
        .attr_wdata (attr_wdata),
        .attr_rdata (attr_rdata),
        .rdy_in     (rdy_in),
        .pwr_ack    (pwr_ack),
        .dev_ien    (dev_ien),
        .irq_req    (irq_req),
        .card_rst   (card_rst),
        .mode_idx   (mode_idx),
        .pwr_down   (pwr_down),
        .stschg_n   (stschg_n),
        .irq_n      (irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        attr_addr  = a;
        attr_wdata = d;
        attr_wr    = 1'b1;
        @(negedge clk);
        attr_wr    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        attr_addr = a;
        attr_rd   = 1'b1;
        #1;
        d = attr_rdata;
        attr_rd = 1'b0;
    endtask

    function automatic logic [11:0] addr_of(input int s);
        return 12'h200 + 12'(2 * s);
    endfunction

    function automatic logic [7:0] exp_read(input int s);
        case (s)
            0: return m_opt;
            1: return m_stat | {3'b0, m_pin[1], 4'b0};
            2: return m_pin | 8'h01;
            default: return m_sock;
        endcase
    endfunction

    function automatic logic exp_stschg();
        return !(m_stat[2] && m_pin[1] && (m_opt[5:0] != 6'd0));
    endfunction

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int lows;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_OPT, d);  chk("R1 option", d, 8'h00);
        rd(A_STAT, d); chk("R1 status", d, 8'h00);
        rd(A_PIN, d);  chk("R1 pin", d, 8'h05);
        rd(A_SOCK, d); chk("R1 socket", d, 8'h00);
        chk("R1 outputs", {card_rst, mode_idx, stschg_n}, 8'h01);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);

        // R13 idle read bus
        attr_addr = A_PIN; #1;
        chk("R13 rdata idle", attr_rdata, 8'h00);

        // R9 socket
        wr(A_SOCK, 8'hFF);
        rd(A_SOCK, d); chk("R9 socket drv", d, 8'h10);
        wr(A_SOCK, 8'h00);

        // R2 option layout
        wr(A_OPT, 8'h2B);
        rd(A_OPT, d); chk("R2 option readback", d, 8'h2B);
        chk("R2 mode_idx", {2'b0, mode_idx}, 8'h2B);

        // R12 odd address and disk-emulation mode
        rd(12'h201, d); chk("R12 odd read", d, 8'h00);
        wr(12'h201, 8'hFF);
        rd(A_OPT, d); chk("R12 odd write ignored", d, 8'h2B);
        ide_mode = 1'b1;
        rd(A_OPT, d); chk("R12 ide read", d, 8'h00);
        wr(A_OPT, 8'h11);
        ide_mode = 1'b0;
        rd(A_OPT, d); chk("R12 ide write ignored", d, 8'h2B);
        wr(A_OPT, 8'h00);

        // random phase: R2 R5 R6 R8 R9 against the model
        m_opt = 8'h00; m_stat = 8'h00; m_pin = 8'h04; m_sock = 8'h00;
        for (int i = 0; i < 300; i++) begin
            int s;
            logic [7:0] v;
            s = int'($urandom % 4);
            v = 8'($urandom);
            case (s)
                0: begin v = v & 8'h7F; m_opt = v; end
                1: begin v = v & 8'hFD; m_stat = v & 8'h0C; end
                2: m_pin = v & 8'h06;
                default: m_sock = v & 8'h10;
            endcase
            wr(addr_of(s), v);
            s = int'($urandom % 4);
            rd(addr_of(s), d);
            chk("R6 R8 random readback", d, exp_read(s));
            chk("R5 random stschg_n", {7'b0, stschg_n}, {7'b0, exp_stschg()});
            chk("R2 random mode_idx", {2'b0, mode_idx}, {2'b0, m_opt[5:0]});
            chk("R11 random irq idle", {7'b0, irq_n}, 8'h01);
        end

        // R5 directed gating
        wr(A_OPT, 8'h01); wr(A_STAT, 8'h04); wr(A_PIN, 8'h06);
        chk("R5 all conditions", {7'b0, stschg_n}, 8'h00);
        wr(A_OPT, 8'h00);
        chk("R5 memory mode", {7'b0, stschg_n}, 8'h01);
        wr(A_OPT, 8'h01); wr(A_STAT, 8'h00);
        chk("R5 enable off", {7'b0, stschg_n}, 8'h01);

        // R4 ready change coinciding with a clearing write
        wr(A_PIN, 8'h04);
        rd(A_PIN, d); chk("R4 cleared", d, 8'h05);
        @(negedge clk);
        rdy_in     = 1'b0;
        attr_addr  = A_PIN;
        attr_wdata = 8'h04;
        attr_wr    = 1'b1;
        @(negedge clk);
        attr_wr = 1'b0;
        rd(A_PIN, d); chk("R4 set wins over write", d, 8'h06);
        wr(A_PIN, 8'h00);
        @(negedge clk);
        rdy_in = 1'b1;
        @(negedge clk);
        rd(A_PIN, d); chk("R4 masked change", d, 8'h01);
        wr(A_PIN, 8'h04);

        // R7 power-down handshake
        wr(A_STAT, 8'h02);
        @(negedge clk);
        rd(A_PIN, d); chk("R7 busy entering", d & 8'h01, 8'h00);
        chk("R7 pwr_down", {7'b0, pwr_down}, 8'h01);
        pwr_ack = 1'b1;
        @(negedge clk);
        rd(A_PIN, d); chk("R7 ready asleep", d & 8'h01, 8'h01);
        wr(A_STAT, 8'h00);
        @(negedge clk);
        rd(A_PIN, d); chk("R7 busy leaving", d & 8'h01, 8'h00);
        pwr_ack = 1'b0;
        @(negedge clk);
        rd(A_PIN, d); chk("R7 ready active", d & 8'h01, 8'h01);
        chk("R7 pwr_down off", {7'b0, pwr_down}, 8'h00);

        // R3 soft reset
        wr(A_SOCK, 8'h10);
        wr(A_OPT, 8'hC5);
        rd(A_OPT, d); chk("R3 option in reset", d, 8'h80);
        chk("R3 card_rst and idx", {card_rst, 1'b0, mode_idx}, 8'h80);
        rd(A_SOCK, d); chk("R3 socket cleared", d, 8'h00);
        wr(A_SOCK, 8'h10);
        rd(A_SOCK, d); chk("R3 write ignored", d, 8'h00);
        rd(A_PIN, d); chk("R3 pin reset", d, 8'h05);
        wr(A_OPT, 8'h00);
        chk("R3 released", {7'b0, card_rst}, 8'h00);

        // R10 pulse interrupt
        dev_ien = 1'b1;
        @(negedge clk);
        irq_req = 1'b1;
        lows = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!irq_n) lows++;
        end
        chk("R10 pulse length", 8'(lows), 8'd4);
        rd(A_STAT, d); chk("R6 intr bit", d & 8'h01, 8'h01);
        irq_req = 1'b0;
        dev_ien = 1'b0;
        @(negedge clk);
        irq_req = 1'b1;
        lows = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!irq_n) lows++;
        end
        chk("R10 masked no pulse", 8'(lows), 8'd0);
        rd(A_STAT, d); chk("R6 intr masked", d & 8'h01, 8'h00);
        irq_req = 1'b0;

        // R11 level interrupt
        wr(A_OPT, 8'h40);
        dev_ien = 1'b1;
        irq_req = 1'b1;
        @(negedge clk);
        chk("R11 level on", {7'b0, irq_n}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R11 level held", {7'b0, irq_n}, 8'h00);
        irq_req = 1'b0;
        @(negedge clk);
        chk("R11 level off", {7'b0, irq_n}, 8'h01);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule